// File: doc/BRIEF.md
# SPI Status and Interrupt Controller

This block keeps the status flags and the interrupt enables of an SPI peripheral. A separate serial engine, outside this block, supplies live condition levels (receive data waiting, transmit holding space free, stalled, last frame of transfer, master fully idle). It also supplies single-cycle event pulses for receive overrun, transmit underrun, select asserted and select deasserted. The block turns the event pulses into sticky flags. It presents a 9-bit status word and lets software clear sticky flags by writing ones. Writing one to status bit 7 sends a single-cycle forced end-of-transfer command back to the engine.

Interrupt enables have their own set port and clear port, so no read-modify-write is needed. The masked interrupt word is the low six status bits ANDed with the enables, and one interrupt line is the OR of that word.

Select transitions are filtered by a two-state machine that tracks whether the select is currently asserted. In state SEL_OFF, an assert pulse moves it to SEL_ON and raises the select-asserted flag. In state SEL_ON, a deassert pulse moves it to SEL_OFF and raises the select-deasserted flag. Every other pulse leaves the state as it is. Reset enters SEL_OFF.

Top module: `spi_stat_irq_ctrl`

## Requirements
- R1: The status word holds the live input levels in the same cycle at these bits: receive ready at 0, transmit ready at 1, stalled at 6, end of transfer at 7, master idle at 8.
- R2: An overrun pulse sets status bit 2 and an underrun pulse sets status bit 3 from the next clock edge on. Each stays set until it is cleared.
- R3: A status write clears each of bits 2 to 5 whose write-data bit is 1 at the next edge. Bits written with 0 keep their value.
- R4: When an event pulse and a clearing write reach the same flag in the same cycle, the flag is set after the edge.
- R5: Status bit 4 (select asserted) is set only by an assert pulse in SEL_OFF. Status bit 5 (select deasserted) is set only by a deassert pulse in SEL_ON. Repeated pulses of the same kind have no effect.
- R6: A status write with data bit 7 at 1 drives force_eot_o high for exactly the next cycle. Write-data bits 0, 1, 6 and 8 have no effect on the status word.
- R7: An enable-set write turns on each enable whose data bit is 1. An enable-clear write turns off each enable whose data bit is 1. If both act on one bit in the same cycle, the clear wins. Enable bit n belongs to status bit n, for n = 0 to 5.
- R8: irq_stat_o equals status bits 5..0 ANDed with the enables, in the same cycle.
- R9: irq_o is high exactly when any irq_stat_o bit is high.
- R10: After reset, the sticky flags, the enables and force_eot_o are 0 and the select tracker is in SEL_OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_ready_i | input | 1 | Live: receive data waiting |
| tx_ready_i | input | 1 | Live: transmit holding space free |
| overrun_i | input | 1 | Pulse: receive overrun |
| underrun_i | input | 1 | Pulse: transmit underrun |
| sel_assert_i | input | 1 | Pulse: select went active |
| sel_deassert_i | input | 1 | Pulse: select went inactive |
| stalled_i | input | 1 | Live: engine stalled |
| eot_i | input | 1 | Live: current frame ends the transfer |
| master_idle_i | input | 1 | Live: master fully idle |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 9 | Status write data (1 clears bits 2..5, 1 at bit 7 forces end) |
| ien_set_wr_i | input | 1 | Enable-set write strobe |
| ien_clr_wr_i | input | 1 | Enable-clear write strobe |
| ien_wdata_i | input | 6 | Data for enable set or clear |
| status_o | output | 9 | Status word |
| ien_o | output | 6 | Current interrupt enables |
| irq_stat_o | output | 6 | Masked interrupt status |
| irq_o | output | 1 | Interrupt request |
| force_eot_o | output | 1 | One-cycle forced end-of-transfer command |

## Verification
The bench targets several corner cases, and each one exposes a specific design error:
- An overrun pulse that lands in the same cycle as its clear. A design that lets the clear win drops an event.
- A second assert pulse while the select is already active. A design without the tracker raises a spurious select-asserted flag.
- An enable set and clear of the same bit in one write cycle. A design with the wrong priority leaves the interrupt enabled.
- A status write with ones in the non-clearable bits. A design that decodes the wrong bits loses live state or sends a false end-of-transfer command.

Random traffic mixes all inputs so that masking and the OR into irq_o are exercised against flags that change state.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
    localparam int STAT_W   = 9;
    localparam int IRQ_W    = 6;
    localparam int STICKY_W = 4;
    localparam int STICKY_LO = 2;

    localparam int B_RXRDY = 0;
    localparam int B_TXRDY = 1;
    localparam int B_OVR   = 2;
    localparam int B_UNR   = 3;
    localparam int B_SELON = 4;
    localparam int B_SELOF = 5;
    localparam int B_STALL = 6;
    localparam int B_EOT   = 7;
    localparam int B_IDLE  = 8;

    typedef enum logic {
        SEL_OFF = 1'b0,
        SEL_ON  = 1'b1
    } sel_state_e;
endpackage

// File: rtl/sel_tracker.sv
module sel_tracker
    import spi_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic assert_i,
    input  logic deassert_i,
    output logic on_evt_o,
    output logic off_evt_o
);
    sel_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        on_evt_o  = 1'b0;
        off_evt_o = 1'b0;
        unique case (state_q)
            SEL_OFF: begin
                if (assert_i) begin
                    state_d  = SEL_ON;
                    on_evt_o = 1'b1;
                end
            end
            SEL_ON: begin
                if (deassert_i) begin
                    state_d   = SEL_OFF;
                    off_evt_o = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= 1'b0;
            else if (set_i[g]) q <= 1'b1;
            else if (clr_i[g]) q <= 1'b0;
        end
        assign flags_o[g] = q;
    end
endmodule

// File: rtl/irq_enable.sv
module irq_enable #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_wr_i,
    input  logic         clr_wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] ien_o
);
    logic [N-1:0] set_m, clr_m, ien_q;

    always_comb begin
        set_m = set_wr_i ? wdata_i : '0;
        clr_m = clr_wr_i ? wdata_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ien_q <= '0;
        else        ien_q <= (ien_q | set_m) & ~clr_m;
    end

    assign ien_o = ien_q;
endmodule

// File: rtl/spi_stat_irq_ctrl.sv
module spi_stat_irq_ctrl
    import spi_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_ready_i,
    input  logic              tx_ready_i,
    input  logic              overrun_i,
    input  logic              underrun_i,
    input  logic              sel_assert_i,
    input  logic              sel_deassert_i,
    input  logic              stalled_i,
    input  logic              eot_i,
    input  logic              master_idle_i,
    input  logic              stat_wr_i,
    input  logic [STAT_W-1:0] stat_wdata_i,
    input  logic              ien_set_wr_i,
    input  logic              ien_clr_wr_i,
    input  logic [IRQ_W-1:0]  ien_wdata_i,
    output logic [STAT_W-1:0] status_o,
    output logic [IRQ_W-1:0]  ien_o,
    output logic [IRQ_W-1:0]  irq_stat_o,
    output logic              irq_o,
    output logic              force_eot_o
);
    logic                sel_on_evt, sel_off_evt;
    logic [STICKY_W-1:0] sticky_set, sticky_clr, sticky;
    logic                force_q;
    logic                unused_wbits;

    sel_tracker i_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .assert_i   (sel_assert_i),
        .deassert_i (sel_deassert_i),
        .on_evt_o   (sel_on_evt),
        .off_evt_o  (sel_off_evt)
    );

    assign sticky_set = {sel_off_evt, sel_on_evt, underrun_i, overrun_i};
    assign sticky_clr = stat_wr_i ? stat_wdata_i[STICKY_LO +: STICKY_W] : '0;

    sticky_flags #(.N(STICKY_W)) i_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (sticky_set),
        .clr_i   (sticky_clr),
        .flags_o (sticky)
    );

    irq_enable #(.N(IRQ_W)) i_ien (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_wr_i (ien_set_wr_i),
        .clr_wr_i (ien_clr_wr_i),
        .wdata_i  (ien_wdata_i),
        .ien_o    (ien_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) force_q <= 1'b0;
        else        force_q <= stat_wr_i & stat_wdata_i[B_EOT];
    end

    always_comb begin
        status_o          = '0;
        status_o[B_RXRDY] = rx_ready_i;
        status_o[B_TXRDY] = tx_ready_i;
        status_o[B_OVR]   = sticky[0];
        status_o[B_UNR]   = sticky[1];
        status_o[B_SELON] = sticky[2];
        status_o[B_SELOF] = sticky[3];
        status_o[B_STALL] = stalled_i;
        status_o[B_EOT]   = eot_i;
        status_o[B_IDLE]  = master_idle_i;
    end

    assign irq_stat_o   = status_o[IRQ_W-1:0] & ien_o;
    assign irq_o        = |irq_stat_o;
    assign force_eot_o  = force_q;
    assign unused_wbits = ^{stat_wdata_i[B_IDLE], stat_wdata_i[B_STALL],
                            stat_wdata_i[B_TXRDY], stat_wdata_i[B_RXRDY]};
endmodule

// File: rtl/spi_stat_irq_chk.sv
module spi_stat_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       overrun_i,
    input logic       underrun_i,
    input logic       stat_wr_i,
    input logic [8:0] stat_wdata_i,
    input logic       ien_clr_wr_i,
    input logic [5:0] ien_wdata_i,
    input logic [8:0] status_o,
    input logic [5:0] ien_o,
    input logic       irq_o,
    input logic       force_eot_o
);
    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[2] && !(stat_wr_i && stat_wdata_i[2])) |=> status_o[2]); // R2
    AST_OVR_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_i |=> status_o[2]); // R4
    AST_UNR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && stat_wdata_i[3] && !underrun_i) |=> !status_o[3]); // R3
    AST_FORCE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && stat_wdata_i[7]) |=> force_eot_o); // R6
    AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_wr_i && stat_wdata_i[7]) |=> !force_eot_o); // R6
    AST_IEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ien_clr_wr_i |=> ((ien_o & $past(ien_wdata_i)) == 6'd0)); // R7
    AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_o == 6'd0) |-> !irq_o); // R9
endmodule

bind spi_stat_irq_ctrl spi_stat_irq_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .overrun_i    (overrun_i),
    .underrun_i   (underrun_i),
    .stat_wr_i    (stat_wr_i),
    .stat_wdata_i (stat_wdata_i),
    .ien_clr_wr_i (ien_clr_wr_i),
    .ien_wdata_i  (ien_wdata_i),
    .status_o     (status_o),
    .ien_o        (ien_o),
    .irq_o        (irq_o),
    .force_eot_o  (force_eot_o)
);

// File: tb/test_spi_stat_irq_ctrl.sv
`timescale 1ns/1ps
module test_spi_stat_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx, tx, ov, ur, sa, sd, st, eo, mi, swr, isw, icw;
    logic [8:0] swd;
    logic [5:0] iwd;
    logic [8:0] status;
    logic [5:0] ien, irqs;
    logic irq, force_eot;

    int n_chk = 0;
    int n_fail = 0;

    // bench model state
    logic m_ov, m_ur, m_ssa, m_ssd, m_sel, m_force;
    logic [5:0] m_ien;

    always #10 clk = ~clk;

    spi_stat_irq_ctrl i_spi_stat_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rx_ready_i(rx), .tx_ready_i(tx), .overrun_i(ov), .underrun_i(ur),
        .sel_assert_i(sa), .sel_deassert_i(sd), .stalled_i(st), .eot_i(eo),
        .master_idle_i(mi), .stat_wr_i(swr), .stat_wdata_i(swd),
        .ien_set_wr_i(isw), .ien_clr_wr_i(icw), .ien_wdata_i(iwd),
        .status_o(status), .ien_o(ien), .irq_stat_o(irqs), .irq_o(irq),
        .force_eot_o(force_eot)
    );

    function automatic logic [8:0] exp_status();
        return {mi, eo, st, m_ssd, m_ssa, m_ur, m_ov, tx, rx};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [8:0] es;
        logic [5:0] eirq;
        es = exp_status();
        eirq = es[5:0] & m_ien;
        chk("R1 live status bits", {status[8:6], status[1:0]}, {es[8:6], es[1:0]});
        chk("R2 R3 R4 overrun/underrun flags", status[3:2], es[3:2]);
        chk("R5 select flags", status[5:4], es[5:4]);
        chk("R6 force_eot", force_eot, m_force);
        chk("R7 enables", ien, m_ien);
        chk("R8 irq_stat", irqs, eirq);
        chk("R9 irq", irq, |eirq);
    endtask

    task automatic model_update();
        logic [8:0] c;
        logic on_e, off_e;
        c = swr ? swd : 9'd0;
        on_e = 1'b0; off_e = 1'b0;
        if (!m_sel && sa) begin on_e = 1'b1; m_sel = 1'b1; end
        else if (m_sel && sd) begin off_e = 1'b1; m_sel = 1'b0; end
        m_ov  = ov    | (m_ov  & ~c[2]);
        m_ur  = ur    | (m_ur  & ~c[3]);
        m_ssa = on_e  | (m_ssa & ~c[4]);
        m_ssd = off_e | (m_ssd & ~c[5]);
        m_ien = (m_ien | (isw ? iwd : 6'd0)) & ~(icw ? iwd : 6'd0);
        m_force = swr & swd[7];
    endtask

    task automatic idle_inputs();
        {rx, tx, ov, ur, sa, sd, st, eo, mi, swr, isw, icw} = '0;
        swd = '0; iwd = '0;
    endtask

    // inputs already set at negedge: check, then advance one cycle
    task automatic cycle();
        #1 check_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        {m_ov, m_ur, m_ssa, m_ssd, m_sel, m_force} = '0;
        m_ien = '0;
        repeat (3) @(negedge clk);
        // R10 reset state while held
        #1;
        chk("R10 reset status", status, 9'd0);
        chk("R10 reset enables", ien, 6'd0);
        chk("R10 reset force", force_eot, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 overrun sets and holds
        ov = 1'b1; cycle();
        cycle();
        // R4 event with clear in same cycle keeps flag
        ov = 1'b1; swr = 1'b1; swd = 9'h004; cycle();
        chk("R4 overrun kept", status[2], 1'b1);
        // R3 clear with zero bits leaving others
        ur = 1'b1; cycle();
        swr = 1'b1; swd = 9'h004; cycle();
        chk("R3 only bit2 cleared", status[3:2], 2'b10);
        // R5 assert, redundant assert ignored after clear
        sa = 1'b1; cycle();
        swr = 1'b1; swd = 9'h010; cycle();
        sa = 1'b1; cycle();
        chk("R5 redundant assert ignored", status[4], 1'b0);
        sd = 1'b1; cycle();
        chk("R5 deassert flag", status[5], 1'b1);
        sd = 1'b1; swr = 1'b1; swd = 9'h020; cycle();
        chk("R5 redundant deassert ignored", status[5], 1'b0);
        // R6 force and non-clearable bits
        rx = 1'b1; st = 1'b1; swr = 1'b1; swd = 9'h1C3; cycle();
        chk("R6 force pulse", force_eot, 1'b1);
        cycle();
        chk("R6 force one cycle", force_eot, 1'b0);
        // R7 set then set+clear same bit
        isw = 1'b1; iwd = 6'h3F; cycle();
        isw = 1'b1; icw = 1'b1; iwd = 6'h01; cycle();
        chk("R7 clear wins", ien[0], 1'b0);
        // R8 R9 masked interrupt with rx ready and enabled tx ready
        tx = 1'b1; cycle();

        for (int i = 0; i < 3000; i++) begin
            rx  = ($urandom % 2) == 0;
            tx  = ($urandom % 2) == 0;
            st  = ($urandom % 2) == 0;
            eo  = ($urandom % 4) == 0;
            mi  = ($urandom % 2) == 0;
            ov  = ($urandom % 8) == 0;
            ur  = ($urandom % 8) == 0;
            sa  = ($urandom % 5) == 0;
            sd  = ($urandom % 5) == 0;
            swr = ($urandom % 4) == 0;
            swd = 9'($urandom);
            isw = ($urandom % 6) == 0;
            icw = ($urandom % 6) == 0;
            iwd = 6'($urandom);
            cycle();
        end
        cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule